// File: doc/BRIEF.md
# Clock Recovery Training Sequencer

This block runs the clock recovery phase of link training for one PHY of a serial display link. A pulse on `start_i` latches the run configuration (sink revision class, active lane count, settle delay), clears every lane's drive byte, and sends a first settings write that also selects training pattern 1 with scrambling off. The block then repeats a loop until a stop condition is met. Each pass waits a programmable settle time, asks for the per-lane link status, and checks whether every active lane has locked its clock. If not, it asks an external drive adjustment calculator for new lane bytes and writes them to the link.

Three separate limits end a run that does not lock. The first is an iteration cap that depends on the sink revision. The second is a limit on how many times in a row lane 0's swing level has been applied unchanged. The third applies when every active lane carried the swing-maximum flag after the last adjustment. A failed status read or a failed settings write ends the run at once. The outcome is a one-cycle `done_o` pulse, with `pass_o` high in that cycle for success.

Top module: `cr_train_seq`

## Requirements
- R1: The first write after `start_i` has `wr_pat_en_o`=1, `wr_pat_o`=8'h21 (pattern code 1 in bits 3:0, scramble-off at bit 5), and all lane bytes zero.
- R2: Between the cycle a settings write is accepted (and does not end the run) and the next status read request, exactly `delay_i`+1 cycles pass with no request raised.
- R3: A status response is a pass when bit 0 of every active lane's 4-bit nibble is set. Lane i is active when i < `lane_cnt_i`, and the nibbles of inactive lanes are ignored. This test is made before every stop condition.
- R4: With `rev14_i`=1 the run fails after 10 adjustment writes without a pass; with `rev14_i`=0 it fails after 80.
- R5: The same-swing count starts at 1. Each accepted adjustment adds one to it when its lane-0 swing (bits 1:0 of lane byte 0) equals the previous lane-0 swing, and otherwise sets it back to 1. A non-passing status read fails the run when the count is 5.
- R6: A non-passing status read fails the run when the latest adjustment carried the swing-maximum flag (bit 2 of the lane byte) on every active lane.
- R7: Each adjustment write has `wr_pat_en_o`=0, `wr_pat_o`=0, and carries exactly the lane bytes the calculator returned.
- R8: A status read accepted with `rd_err_i`=1 ends the run with fail in the next cycle, and no adjustment is requested.
- R9: A settings write accepted with `wr_err_i`=1 ends the run with fail in the next cycle, and no further status read is requested.
- R10: After reset and between runs, all requests and `done_o`/`pass_o` are low. `done_o` is a single-cycle pulse, `pass_o` is high only with it, at most one request is raised at a time, and each request is held until its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a run (accepted when idle) |
| rev14_i | input | 1 | Sink revision is 1.4 or later |
| lane_cnt_i | input | 3 | Number of active lanes |
| delay_i | input | 8 | Settle delay in cycles |
| done_o | output | 1 | Run finished (one cycle) |
| pass_o | output | 1 | Run passed, valid with done_o |
| rd_req_o | output | 1 | Status read request |
| rd_ack_i | input | 1 | Status read response |
| rd_err_i | input | 1 | Status read failed |
| rd_status_i | input | 16 | Per-lane 4-bit status nibbles |
| wr_req_o | output | 1 | Settings write request |
| wr_pat_en_o | output | 1 | Write also carries the pattern byte |
| wr_pat_o | output | 8 | Pattern byte |
| wr_lanes_o | output | 32 | Per-lane drive bytes |
| wr_ack_i | input | 1 | Settings write response |
| wr_err_i | input | 1 | Settings write failed |
| calc_req_o | output | 1 | Drive adjustment request |
| calc_ack_i | input | 1 | Calculator result valid |
| calc_set_i | input | 32 | New per-lane drive bytes |

## Verification
The bench targets the order of the exit tests. A run that locks on the same read that would trip the same-swing limit, or right after an all-maximum adjustment, must still pass; a design that tests the stop conditions first would report fail there. The bench drives the two cap values, stuck swings that start at zero and at a nonzero level, and swing-maximum flags set on only some lanes. A counter that is off by one, or that starts at 0 instead of 1, changes the number of reads and adjustments and is caught. Partial lane counts with an inactive lane left unlocked check the lane masking. Errors injected on the first write, a later write, and several reads check that the run stops at once instead of asking for one more transaction.

// File: rtl/crs_pkg.sv
package crs_pkg;
  localparam int LANE_BYTE_W = 8;
  localparam int STAT_NIB_W  = 4;
  localparam int CR_DONE_BIT = 0;
  localparam int SWING_LSB   = 0;
  localparam int SWING_W     = 2;
  localparam int SWING_MAX_BIT = 2;
  localparam logic [7:0] PAT1_NO_SCRAMBLE = 8'h21;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT_WR,
    ST_WAIT,
    ST_READ,
    ST_CALC,
    ST_UPD_WR,
    ST_DONE
  } crs_state_e;
endpackage

// File: rtl/crs_delay_timer.sv
module crs_delay_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)
      cnt_d = load_val_i;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // R2: the settle count falls by one each cycle until it reaches zero
  a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/crs_lane_eval.sv
module crs_lane_eval
  import crs_pkg::*;
#(
  parameter int NLANES = 4,
  parameter int LCNT_W = 3
) (
  input  logic [LCNT_W-1:0]             lane_cnt_i,
  input  logic [NLANES*STAT_NIB_W-1:0]  status_i,
  input  logic [NLANES*LANE_BYTE_W-1:0] set_i,
  output logic                          cr_all_o,
  output logic                          swmax_all_o
);
  logic [NLANES-1:0] cr_ok, mx_ok;

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    logic active;
    logic [STAT_NIB_W-1:0] nib;
    logic unused_nib_hi;
    assign active = (lane_cnt_i > LCNT_W'(i));
    assign nib    = status_i[i*STAT_NIB_W +: STAT_NIB_W];
    assign unused_nib_hi = ^nib[STAT_NIB_W-1:1];
    assign cr_ok[i] = !active || nib[CR_DONE_BIT];
    assign mx_ok[i] = !active || set_i[i*LANE_BYTE_W + SWING_MAX_BIT];
  end

  assign cr_all_o    = &cr_ok;
  assign swmax_all_o = &mx_ok;
endmodule

// File: rtl/crs_retry_track.sv
module crs_retry_track #(
  parameter int CAP_HI   = 10,
  parameter int CAP_LO   = 80,
  parameter int SAME_LIM = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic rev14_i,
  input  logic adj_i,
  input  logic same_i,
  input  logic allmax_i,
  input  logic iter_i,
  output logic last_iter_o,
  output logic same_lim_o,
  output logic maxsw_o
);
  localparam int CAP_MAX = (CAP_HI > CAP_LO) ? CAP_HI : CAP_LO;
  localparam int IT_W    = $clog2(CAP_MAX + 1);
  localparam int SL_W    = $clog2(SAME_LIM + 1);

  logic [IT_W-1:0] it_q, it_d, cap_sel;
  logic [SL_W-1:0] vt_q, vt_d;
  logic            mx_q, mx_d;

  always_comb begin
    it_d = it_q;
    vt_d = vt_q;
    mx_d = mx_q;
    if (clr_i) begin
      it_d = '0;
      vt_d = SL_W'(1);
      mx_d = 1'b0;
    end else begin
      if (iter_i) it_d = it_q + 1'b1;
      if (adj_i) begin
        vt_d = same_i ? vt_q + 1'b1 : SL_W'(1);
        mx_d = allmax_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      it_q <= '0;
      vt_q <= SL_W'(1);
      mx_q <= 1'b0;
    end else begin
      it_q <= it_d;
      vt_q <= vt_d;
      mx_q <= mx_d;
    end
  end

  assign cap_sel     = rev14_i ? IT_W'(CAP_HI) : IT_W'(CAP_LO);
  assign last_iter_o = (it_q == cap_sel - 1'b1);
  assign same_lim_o  = (vt_q == SL_W'(SAME_LIM));
  assign maxsw_o     = mx_q;

  // R4: the iteration count never passes the selected cap
  a_r4_cap_bound: assert property (@(posedge clk) disable iff (!rst_n)
    it_q <= cap_sel);
  // R5: the same-swing count stays within 1..limit
  a_r5_same_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (vt_q != '0) && (vt_q <= SL_W'(SAME_LIM)));
endmodule

// File: rtl/cr_train_seq.sv
module cr_train_seq
  import crs_pkg::*;
#(
  parameter int NLANES   = 4,
  parameter int DLY_W    = 8,
  parameter int CAP_HI   = 10,
  parameter int CAP_LO   = 80,
  parameter int SAME_LIM = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic                          rev14_i,
  input  logic [$clog2(NLANES+1)-1:0]   lane_cnt_i,
  input  logic [DLY_W-1:0]              delay_i,
  output logic                          done_o,
  output logic                          pass_o,
  output logic                          rd_req_o,
  input  logic                          rd_ack_i,
  input  logic                          rd_err_i,
  input  logic [NLANES*STAT_NIB_W-1:0]  rd_status_i,
  output logic                          wr_req_o,
  output logic                          wr_pat_en_o,
  output logic [7:0]                    wr_pat_o,
  output logic [NLANES*LANE_BYTE_W-1:0] wr_lanes_o,
  input  logic                          wr_ack_i,
  input  logic                          wr_err_i,
  output logic                          calc_req_o,
  input  logic                          calc_ack_i,
  input  logic [NLANES*LANE_BYTE_W-1:0] calc_set_i
);
  localparam int LCNT_W = $clog2(NLANES + 1);
  localparam int DRV_W  = NLANES * LANE_BYTE_W;

  crs_state_e state_q, state_d;
  logic              pass_q, pass_d;
  logic              rev_q;
  logic [LCNT_W-1:0] lcnt_q;
  logic [DLY_W-1:0]  dly_q;
  logic [DRV_W-1:0]  drv_q, drv_d;
  logic              cfg_en, drv_en;

  logic start_ok, rd_hs, wr_hs, calc_hs;
  logic cr_all, swmax_all, tmr_zero, tmr_load;
  logic last_iter, same_lim, maxsw, same_sw, iter_done;

  assign start_ok = (state_q == ST_IDLE) && start_i;
  assign rd_hs    = rd_req_o && rd_ack_i;
  assign wr_hs    = wr_req_o && wr_ack_i;
  assign calc_hs  = calc_req_o && calc_ack_i;
  assign same_sw  = calc_set_i[SWING_LSB +: SWING_W] == drv_q[SWING_LSB +: SWING_W];
  assign iter_done = (state_q == ST_UPD_WR) && wr_hs && !wr_err_i;
  assign tmr_load  = wr_hs && !wr_err_i && !((state_q == ST_UPD_WR) && last_iter);

  crs_delay_timer #(.W(DLY_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (dly_q),
    .zero_o     (tmr_zero)
  );

  crs_lane_eval #(.NLANES(NLANES), .LCNT_W(LCNT_W)) u_lanes (
    .lane_cnt_i  (lcnt_q),
    .status_i    (rd_status_i),
    .set_i       (calc_set_i),
    .cr_all_o    (cr_all),
    .swmax_all_o (swmax_all)
  );

  crs_retry_track #(.CAP_HI(CAP_HI), .CAP_LO(CAP_LO), .SAME_LIM(SAME_LIM)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (start_ok),
    .rev14_i     (rev_q),
    .adj_i       (calc_hs),
    .same_i      (same_sw),
    .allmax_i    (swmax_all),
    .iter_i      (iter_done),
    .last_iter_o (last_iter),
    .same_lim_o  (same_lim),
    .maxsw_o     (maxsw)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    pass_d  = pass_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_INIT_WR;
        pass_d  = 1'b0;
      end
      ST_INIT_WR: if (wr_ack_i)
        state_d = wr_err_i ? ST_DONE : ST_WAIT;
      ST_WAIT: if (tmr_zero)
        state_d = ST_READ;
      ST_READ: if (rd_ack_i) begin
        if (rd_err_i)
          state_d = ST_DONE;
        else if (cr_all) begin
          state_d = ST_DONE;
          pass_d  = 1'b1;
        end else if (same_lim || maxsw)
          state_d = ST_DONE;
        else
          state_d = ST_CALC;
      end
      ST_CALC: if (calc_ack_i)
        state_d = ST_UPD_WR;
      ST_UPD_WR: if (wr_ack_i)
        state_d = (wr_err_i || last_iter) ? ST_DONE : ST_WAIT;
      ST_DONE:
        state_d = ST_IDLE;
      default:
        state_d = ST_IDLE;
    endcase
  end

  assign cfg_en = start_ok;
  assign drv_en = start_ok || calc_hs;
  assign drv_d  = start_ok ? '0 : calc_set_i;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pass_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pass_q  <= pass_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rev_q  <= 1'b0;
      lcnt_q <= '0;
      dly_q  <= '0;
    end else if (cfg_en) begin
      rev_q  <= rev14_i;
      lcnt_q <= lane_cnt_i;
      dly_q  <= delay_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      drv_q <= '0;
    else if (drv_en) drv_q <= drv_d;
  end

  assign rd_req_o    = (state_q == ST_READ);
  assign calc_req_o  = (state_q == ST_CALC);
  assign wr_req_o    = (state_q == ST_INIT_WR) || (state_q == ST_UPD_WR);
  assign wr_pat_en_o = (state_q == ST_INIT_WR);
  assign wr_pat_o    = wr_pat_en_o ? PAT1_NO_SCRAMBLE : 8'h00;
  assign wr_lanes_o  = drv_q;
  assign done_o      = (state_q == ST_DONE);
  assign pass_o      = done_o && pass_q;

  // R10: one request at a time, pass only with done, done is a pulse
  a_r10_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req_o, wr_req_o, calc_req_o}));
  a_r10_pass_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |-> done_o);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_ack_i) |=> rd_req_o);
  // R1: the pattern write carries cleared lane bytes
  a_r1_init_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pat_en_o |-> (wr_lanes_o == '0));
  // R7: an accepted adjustment is written next, unchanged
  a_r7_update_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    calc_hs |=> (wr_req_o && !wr_pat_en_o && wr_lanes_o == $past(calc_set_i)));
  // R3: all active lanes locked gives a pass
  a_r3_pass_on_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hs && !rd_err_i && cr_all) |=> pass_o);
  // R8: a failed read ends the run with fail
  a_r8_read_err: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hs && rd_err_i) |=> (done_o && !pass_o));
  // R9: a failed write ends the run with fail
  a_r9_write_err: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hs && wr_err_i) |=> (done_o && !pass_o));
endmodule

// File: tb/cr_train_seq_tb_top.sv
`timescale 1ns/1ps
module cr_train_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, rev14 = 1'b0;
  logic [2:0] lane_cnt = 3'd4;
  logic [7:0] delay = 8'd0;
  logic done_o, pass_o, rd_req_o, wr_req_o, wr_pat_en_o, calc_req_o;
  logic [7:0] wr_pat_o;
  logic [31:0] wr_lanes_o;
  logic rd_ack = 1'b0, rd_err = 1'b0, wr_ack = 1'b0, wr_err = 1'b0, calc_ack = 1'b0;
  logic [15:0] rd_status = '0;
  logic [31:0] calc_set = '0;
  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  cr_train_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .rev14_i(rev14),
    .lane_cnt_i(lane_cnt), .delay_i(delay),
    .done_o(done_o), .pass_o(pass_o),
    .rd_req_o(rd_req_o), .rd_ack_i(rd_ack), .rd_err_i(rd_err), .rd_status_i(rd_status),
    .wr_req_o(wr_req_o), .wr_pat_en_o(wr_pat_en_o), .wr_pat_o(wr_pat_o),
    .wr_lanes_o(wr_lanes_o), .wr_ack_i(wr_ack), .wr_err_i(wr_err),
    .calc_req_o(calc_req_o), .calc_ack_i(calc_ack), .calc_set_i(calc_set)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected outcome and transaction counts, from the requirements
  task automatic predict(input bit rev, input int lanes, input int pass_it, input int swc,
                         input int max_it, input logic [3:0] mmask, input int rderr_it,
                         input int wrerr_it, output bit ep, output int erd, output int ewr,
                         output int ec);
    int cap;
    int vt;
    int it;
    int prev;
    int sw;
    bit mx;
    bit same;
    logic [3:0] lm;
    cap = rev ? 10 : 80;
    vt = 1; it = 0; prev = 0; mx = 1'b0;
    lm = 4'((1 << lanes) - 1);
    ep = 1'b0; erd = 0; ewr = 1; ec = 0;
    if (wrerr_it == 0) return;
    forever begin
      erd++;
      if (rderr_it == erd - 1) return;
      if (pass_it == it) begin ep = 1'b1; return; end
      if (vt == 5 || mx) return;
      sw = (swc >= 0) ? swc : (ec % 2) + 1;
      same = (sw == prev);
      prev = sw;
      mx = (ec == max_it) && ((mmask & lm) == lm);
      ec++;
      ewr++;
      if (wrerr_it == ewr - 1) return;
      vt = same ? vt + 1 : 1;
      it++;
      if (it == cap) return;
    end
  endtask

  task automatic run_case(input string tag, input bit rev, input int lanes, input int dly,
                          input int pass_it, input int swc, input int max_it,
                          input logic [3:0] mmask, input int rderr_it, input int wrerr_it);
    bit ep, got_pass, finished, gap_on;
    int erd, ewr, ec;
    int nrd, nwr, nc, bad_init, bad_upd, bad_gap, gap, guard, sw;
    logic [31:0] last_set;
    logic [3:0] mm;
    predict(rev, lanes, pass_it, swc, max_it, mmask, rderr_it, wrerr_it, ep, erd, ewr, ec);
    nrd = 0; nwr = 0; nc = 0; bad_init = 0; bad_upd = 0; bad_gap = 0; gap = 0; guard = 0;
    gap_on = 1'b0; finished = 1'b0; got_pass = 1'b0; last_set = '0;
    @(negedge clk);
    rev14 = rev; lane_cnt = 3'(lanes); delay = 8'(dly); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!finished && guard < 20000) begin
      rd_ack = 1'b0; rd_err = 1'b0; wr_ack = 1'b0; wr_err = 1'b0; calc_ack = 1'b0;
      if (done_o) begin
        finished = 1'b1;
        got_pass = pass_o;
      end else if (wr_req_o) begin
        if (nwr == 0) begin
          if (!(wr_pat_en_o && wr_pat_o == 8'h21 && wr_lanes_o == '0)) bad_init++;
        end else begin
          if (!(!wr_pat_en_o && wr_pat_o == 8'h00 && wr_lanes_o == last_set)) bad_upd++;
        end
        wr_ack = 1'b1;
        wr_err = (nwr == wrerr_it);
        nwr++;
        gap = 0; gap_on = 1'b1;
      end else if (rd_req_o) begin
        if (gap_on && gap != dly + 1) bad_gap++;
        gap_on = 1'b0;
        rd_ack = 1'b1;
        rd_err = (nrd == rderr_it);
        for (int i = 0; i < 4; i++) begin
          if (nrd == pass_it)
            rd_status[i*4 +: 4] = (i < lanes) ? 4'h7 : 4'h0;
          else
            rd_status[i*4 +: 4] = (i == nrd % lanes) ? 4'hE : 4'h1;
        end
        nrd++;
      end else if (calc_req_o) begin
        sw = (swc >= 0) ? swc : (nc % 2) + 1;
        mm = (nc == max_it) ? mmask : 4'h0;
        for (int i = 0; i < 4; i++)
          calc_set[i*8 +: 8] = {3'b000, 2'(i), mm[i], 2'(sw)};
        last_set = calc_set;
        calc_ack = 1'b1;
        nc++;
      end else if (gap_on) begin
        gap++;
      end
      if (!finished) @(negedge clk);
      guard++;
    end
    rd_ack = 1'b0; rd_err = 1'b0; wr_ack = 1'b0; wr_err = 1'b0; calc_ack = 1'b0;
    chk(finished, tag, "run finished", int'(finished), 1);
    chk(got_pass == ep, tag, "outcome pass", int'(got_pass), int'(ep));
    chk(nrd == erd, tag, "status reads", nrd, erd);
    chk(nc == ec, tag, "adjust requests", nc, ec);
    chk(nwr == ewr, tag, "settings writes", nwr, ewr);
    chk(bad_init == 0, "R1", "bad initial writes", bad_init, 0);
    chk(bad_upd == 0, "R7", "bad update writes", bad_upd, 0);
    chk(bad_gap == 0, "R2", "bad settle gaps", bad_gap, 0);
    @(negedge clk);
    chk(!done_o && !pass_o, "R10", "done held after run", int'(done_o), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R10 watchdog expired: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!done_o && !pass_o && !rd_req_o && !wr_req_o && !calc_req_o, "R10",
        "idle outputs in reset", int'({done_o, pass_o, rd_req_o, wr_req_o, calc_req_o}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!done_o && !rd_req_o && !wr_req_o && !calc_req_o, "R10",
        "idle outputs after reset", int'({done_o, rd_req_o, wr_req_o, calc_req_o}), 0);

    // R3: lock reached after 0..4 adjustments for 1, 2 and 4 lanes, varied delay
    for (int l = 1; l <= 4; l = l * 2)
      for (int p = 0; p < 5; p++)
        run_case("R3", 1'b1, l, p, p, -1, -1, 4'h0, -1, -1);
    // R4: iteration caps for both revision classes
    run_case("R4", 1'b1, 4, 1, -1, -1, -1, 4'h0, -1, -1);
    run_case("R4", 1'b0, 2, 0, -1, -1, -1, 4'h0, -1, -1);
    // R5: swing stuck at its cleared value, and stuck after one change
    run_case("R5", 1'b1, 4, 2, -1, 0, -1, 4'h0, -1, -1);
    run_case("R5", 1'b0, 1, 1, -1, 2, -1, 4'h0, -1, -1);
    // R3 priority: lock on the read that would trip the same-swing stop
    run_case("R3", 1'b1, 4, 0, 4, 0, -1, 4'h0, -1, -1);
    // R6: all active lanes at maximum, partial flags, masked inactive lane
    run_case("R6", 1'b1, 4, 1, -1, -1, 2, 4'hF, -1, -1);
    run_case("R6", 1'b1, 4, 0, -1, -1, 2, 4'h7, -1, -1);
    run_case("R6", 1'b0, 2, 0, -1, -1, 0, 4'h3, -1, -1);
    // R3 priority: lock right after an all-maximum adjustment
    run_case("R3", 1'b1, 4, 0, 2, -1, 1, 4'hF, -1, -1);
    // R8: read errors on the first and a later read
    run_case("R8", 1'b1, 4, 0, -1, -1, -1, 4'h0, 0, -1);
    run_case("R8", 1'b1, 2, 3, -1, -1, -1, 4'h0, 3, -1);
    // R9: write errors on the pattern write and a later update
    run_case("R9", 1'b1, 4, 0, -1, -1, -1, 4'h0, -1, 0);
    run_case("R9", 1'b0, 4, 2, -1, -1, -1, 4'h0, -1, 2);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule